// File: doc/BRIEF.md
# General-Purpose I/O Port with Timer Pin Takeover

This block is a seven-pin bidirectional I/O port. Software reaches it over a small synchronous register bus. There is one register for the output latch and one for the pin directions. The block drives a pad output value and a pad output enable for every pin, and it samples the pad inputs through a two-stage synchronizer. Reads of the latch address return a per-pin blend: the latch for pins set as outputs, and the synchronized pin level for pins set as inputs.

Two of the pins, pin 4 and pin 5, can be claimed by timer channel 0 and channel 1. Each channel has a two-bit mode select. Any nonzero mode hands the pin's pad value and enable to that timer channel. While the timer holds a pin, the direction bit no longer steers the pad. It still chooses what a read of the latch address returns for that pin. The synchronized pin level always goes to each channel's capture input.

The bus is plain control traffic: a write takes effect on the clock edge where the strobe is high, and the read data is a combinational function of the address and the current state. There is no back-pressure. The bus never stalls and every access completes in its own cycle.

Top module: `gpio_tpo`

## Requirements
- R1: While reset is asserted and just after its release, the direction and latch registers are 0, so every pin not held by the timer has its output enable low, and the direction address reads 0x00.
- R2: A write to address 0x0D loads write-data bits 6..0 into the direction register, effective from the next cycle. A read of 0x0D returns the register in bits 6..0, and bit 7 is always 0.
- R3: A write to address 0x05 loads write-data bits 6..0 into the output latch whatever the direction bits are. For every pin not held by the timer, the pad output value equals its latch bit, even while that pin's output enable is low.
- R4: For every pin not held by the timer, the pad output enable equals its direction bit (1 = output, 0 = input).
- R5: A read of 0x05 returns, in bits 6..0, the latch bit for each pin whose direction bit is 1 and the synchronized pin level for each pin whose direction bit is 0. Bit 7 is 0.
- R6: A pad input change is first seen by reads and by the capture outputs after exactly two rising clock edges, and not after one.
- R7: Channel c (0 or 1) holds pin 4+c whenever its mode select tim_sel[2c+1:2c] is nonzero. The pad output value and enable of that pin then come from tim_out[c] and tim_oe[c]. Mode 00 returns the pin to port control.
- R8: While the timer holds a pin, a read of 0x05 still uses that pin's direction bit to choose between the latch and the synchronized level.
- R9: tim_cap[c] always equals the synchronized level of pin 4+c, whatever the mode and direction.
- R10: Reads of any address other than 0x05 and 0x0D return 0x00. Writes to any other address change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 7 | Raw pad input levels |
| pad_out | output | 7 | Pad output values |
| pad_oe | output | 7 | Pad output enables |
| tim_sel | input | 4 | Mode select, two bits per channel (channel c at bits 2c+1:2c) |
| tim_out | input | 2 | Timer channel output values |
| tim_oe | input | 2 | Timer channel output enables |
| tim_cap | output | 2 | Synchronized pin levels to the timer capture inputs |

## Verification
Random traffic mixes writes to both registers and to unmapped addresses with random pad levels, mode selects and timer drives. A bench model predicts every output. Comparing direction and mode bits pin by pin shows whether the timer's claim on a pin and the direction bit's choice of read source act on their own or are wrongly tied together. Directed cases cover reset, a pad change seen one edge and then two edges after it happens (which pins down the synchronizer depth), preloading the latch while pins are inputs, and every nonzero mode value against mode 00.

// File: rtl/gpio_tpo_pkg.sv
package gpio_tpo_pkg;
  parameter int PORT_W   = 7;
  parameter int BUS_W    = 8;
  parameter int ADDR_W   = 8;
  parameter int NUM_CH   = 2;
  parameter int CH_BASE  = 4;
  parameter int SEL_W    = 2;
  parameter int SYNC_LEN = 2;
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h05;
  parameter logic [ADDR_W-1:0] DIR_ADDR   = 8'h0D;

  typedef logic [PORT_W-1:0] port_vec_t;
  typedef logic [BUS_W-1:0]  bus_word_t;
endpackage

// File: rtl/gpio_tpo_sync.sv
module gpio_tpo_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_tpo_regs.sv
module gpio_tpo_regs
  import gpio_tpo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  bus_word_t         bus_wdata,
  output bus_word_t         bus_rdata,
  input  port_vec_t         pin_sync,
  output port_vec_t         latch_q,
  output port_vec_t         dir_q
);
  localparam int PAD_W = BUS_W - PORT_W;

  logic hit_latch, hit_dir;
  port_vec_t port_view;

  assign hit_latch = (bus_addr == LATCH_ADDR);
  assign hit_dir   = (bus_addr == DIR_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                latch_q <= '0;
    else if (bus_wr && hit_latch) latch_q <= bus_wdata[PORT_W-1:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              dir_q <= '0;
    else if (bus_wr && hit_dir) dir_q <= bus_wdata[PORT_W-1:0];

  // per-pin read source: latch when output, synchronized level when input
  assign port_view = (dir_q & latch_q) | (~dir_q & pin_sync);

  always_comb begin
    bus_rdata = '0;
    if (hit_latch)    bus_rdata = {{PAD_W{1'b0}}, port_view};
    else if (hit_dir) bus_rdata = {{PAD_W{1'b0}}, dir_q};
  end
endmodule

// File: rtl/gpio_tpo_pinmux.sv
module gpio_tpo_pinmux
  import gpio_tpo_pkg::*;
(
  input  port_vec_t                 latch_q,
  input  port_vec_t                 dir_q,
  input  port_vec_t                 pin_sync,
  input  logic [NUM_CH*SEL_W-1:0]   tim_sel,
  input  logic [NUM_CH-1:0]         tim_out,
  input  logic [NUM_CH-1:0]         tim_oe,
  output port_vec_t                 pad_out,
  output port_vec_t                 pad_oe,
  output logic [NUM_CH-1:0]         tim_cap
);
  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    if (i >= CH_BASE && i < CH_BASE + NUM_CH) begin : g_shared
      localparam int C = i - CH_BASE;
      logic owned;
      assign owned      = |tim_sel[C*SEL_W +: SEL_W];
      assign pad_out[i] = owned ? tim_out[C] : latch_q[i];
      assign pad_oe[i]  = owned ? tim_oe[C]  : dir_q[i];
    end else begin : g_plain
      assign pad_out[i] = latch_q[i];
      assign pad_oe[i]  = dir_q[i];
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cap
    assign tim_cap[c] = pin_sync[CH_BASE + c];
  end
endmodule

// File: rtl/gpio_tpo.sv
module gpio_tpo
  import gpio_tpo_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [PORT_W-1:0]         pad_in,
  output logic [PORT_W-1:0]         pad_out,
  output logic [PORT_W-1:0]         pad_oe,
  input  logic [NUM_CH*SEL_W-1:0]   tim_sel,
  input  logic [NUM_CH-1:0]         tim_out,
  input  logic [NUM_CH-1:0]         tim_oe,
  output logic [NUM_CH-1:0]         tim_cap
);
  port_vec_t pin_sync, latch_q, dir_q;

  gpio_tpo_sync #(.WIDTH(PORT_W), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pin_sync)
  );

  gpio_tpo_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_tpo_pinmux u_mux (
    .latch_q(latch_q), .dir_q(dir_q), .pin_sync(pin_sync),
    .tim_sel(tim_sel), .tim_out(tim_out), .tim_oe(tim_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .tim_cap(tim_cap)
  );
endmodule

// File: rtl/gpio_tpo_chk.sv
module gpio_tpo_chk
  import gpio_tpo_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_wr,
  input logic [BUS_W-1:0]        bus_wdata,
  input logic [BUS_W-1:0]        bus_rdata,
  input logic [PORT_W-1:0]       pad_in,
  input logic [PORT_W-1:0]       pad_out,
  input logic [PORT_W-1:0]       pad_oe,
  input logic [NUM_CH*SEL_W-1:0] tim_sel,
  input logic [NUM_CH-1:0]       tim_out,
  input logic [NUM_CH-1:0]       tim_oe,
  input logic [NUM_CH-1:0]       tim_cap
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR) |=>
      (bus_addr != DIR_ADDR || bus_rdata == {1'b0, $past(bus_wdata[PORT_W-1:0])}));

  a_r2_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DIR_ADDR || bus_addr == LATCH_ADDR) |-> !bus_rdata[BUS_W-1]);

  a_r7_ch0_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (|tim_sel[1:0]) |-> (pad_oe[CH_BASE] == tim_oe[0] && pad_out[CH_BASE] == tim_out[0]));

  a_r7_ch1_takes_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (|tim_sel[3:2]) |-> (pad_oe[CH_BASE+1] == tim_oe[1] && pad_out[CH_BASE+1] == tim_out[1]));

  a_r6_capture_lag: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |->
      (tim_cap == {$past(pad_in[CH_BASE+1], 2), $past(pad_in[CH_BASE], 2)}));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != DIR_ADDR && bus_addr != LATCH_ADDR) |-> bus_rdata == '0);

  a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == LATCH_ADDR && tim_sel == '0) |=>
      (tim_sel != '0 || pad_out == $past(bus_wdata[PORT_W-1:0])));
endmodule

bind gpio_tpo gpio_tpo_chk u_chk (.*);

// File: tb/sim_gpio_tpo.sv
`timescale 1ns/1ps
module sim_gpio_tpo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] pad_in = '0;
  logic [6:0] pad_out, pad_oe;
  logic [3:0] tim_sel = '0;
  logic [1:0] tim_out = '0, tim_oe = '0, tim_cap;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_tpo u0 (.*);

  // bench model of registers and synchronizer
  logic [6:0] m_dir, m_dat, m_s1, m_s2;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m_dir <= '0; m_dat <= '0; m_s1 <= '0; m_s2 <= '0;
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1;
      if (bus_wr && bus_addr == 8'h0D) m_dir <= bus_wdata[6:0];
      if (bus_wr && bus_addr == 8'h05) m_dat <= bus_wdata[6:0];
    end

  function automatic logic [6:0] own_mask(logic [3:0] sel);
    own_mask = {1'b0, |sel[3:2], |sel[1:0], 4'b0};
  endfunction

  function automatic logic [6:0] exp_oe(logic [6:0] d, logic [3:0] sel, logic [1:0] toe);
    logic [6:0] m = own_mask(sel);
    exp_oe = (d & ~m) | ({1'b0, toe, 4'b0} & m);
  endfunction

  function automatic logic [6:0] exp_out(logic [6:0] l, logic [3:0] sel, logic [1:0] tout);
    logic [6:0] m = own_mask(sel);
    exp_out = (l & ~m) | ({1'b0, tout, 4'b0} & m);
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a, logic [6:0] d, logic [6:0] l, logic [6:0] s);
    if (a == 8'h05)      exp_rd = {1'b0, (d & l) | (~d & s)};
    else if (a == 8'h0D) exp_rd = {1'b0, d};
    else                 exp_rd = 8'h00;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string rtag;
    if (bus_addr == 8'h05) rtag = (tim_sel != 0) ? "R8 read" : "R5 read";
    else if (bus_addr == 8'h0D) rtag = "R2 read";
    else rtag = "R10 read";
    chk(rtag, bus_rdata, exp_rd(bus_addr, m_dir, m_dat, m_s2));
    chk((tim_sel != 0) ? "R7 oe" : "R4 oe", {1'b0, pad_oe}, {1'b0, exp_oe(m_dir, tim_sel, tim_oe)});
    chk((tim_sel != 0) ? "R7 out" : "R3 out", {1'b0, pad_out}, {1'b0, exp_out(m_dat, tim_sel, tim_out)});
    chk("R9 cap", {6'b0, tim_cap}, {6'b0, m_s2[5:4]});
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    bus_addr = 8'h0D;
    #1;
    chk("R1 dir in reset", bus_rdata, 8'h00);
    chk("R1 oe in reset", {1'b0, pad_oe}, 8'h00);
    rst_n = 1'b1;
    cyc();
    chk("R1 dir after reset", bus_rdata, 8'h00);
    chk("R1 oe after reset", {1'b0, pad_oe}, 8'h00);

    // R6: pad change seen after two edges only
    bus_addr = 8'h05; pad_in = 7'h55;
    cyc();
    chk("R6 one edge", bus_rdata, 8'h00);
    cyc();
    chk("R6 two edges", bus_rdata, 8'h55);
    chk("R6 capture", {6'b0, tim_cap}, {6'b0, 2'b01});

    // R3: preload latch while inputs, then switch to output
    wr(8'h05, 8'hAA);
    chk("R3 latch on pad_out as input", {1'b0, pad_out}, 8'h2A);
    chk("R3 oe still low", {1'b0, pad_oe}, 8'h00);
    wr(8'h0D, 8'hFF);
    chk("R2 dir bit7 dropped", bus_rdata, 8'h7F);
    bus_addr = 8'h05; #1;
    chk("R5 all outputs read latch", bus_rdata, 8'h2A);

    // R10: unmapped write ignored
    wr(8'h06, 8'h00);
    bus_addr = 8'h0D; #1;
    chk("R10 dir untouched", bus_rdata, 8'h7F);
    bus_addr = 8'h05; #1;
    chk("R10 latch untouched", bus_rdata, 8'h2A);

    // R7/R8: every mode for each channel
    for (int v = 0; v < 16; v++) begin
      tim_sel = v[3:0]; tim_out = 2'b10; tim_oe = 2'b01;
      #1;
      check_all();
    end
    wr(8'h0D, 8'h00);
    tim_sel = 4'b1010; #1;
    check_all();

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 3);
      bus_addr  = (r == 0) ? 8'h05 : (r == 1) ? 8'h0D : 8'($urandom);
      bus_wr    = ($urandom_range(0, 2) == 0);
      bus_wdata = 8'($urandom);
      pad_in    = 7'($urandom);
      tim_sel   = ($urandom_range(0, 2) == 0) ? 4'h0 : 4'($urandom);
      tim_out   = 2'($urandom);
      tim_oe    = 2'($urandom);
      #1;
      check_all();
      cyc();
      check_all();
    end
    bus_wr = 1'b0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    process::self().srandom(32'd2024);
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule